// File: doc/BRIEF.md
# Vector-to-Scalar Instruction Expander

This block sits between an instruction decoder and a scalar execution pipeline. It takes one decoded three-register instruction (opcode, destination, two sources) at a time and unrolls it into a run of scalar element instructions, which it writes into a 16-entry output queue. A per-register configuration table decides how the unrolling goes. Each of the 32 registers has a vectorised flag, a vector length and a 16-bit predicate mask. For element `i`, a vectorised operand is renamed to its base register number plus `i`, and a scalar operand keeps its number. The opcode is copied into every element without change.

The length and the mask come from the destination register's entry. Elements are visited in ascending order, and any element whose mask bit is clear produces nothing. An instruction that touches no vectorised register, or whose length is 1, goes through as exactly one unchanged entry. If a renamed register number would pass 31, the block raises an error flag and drops that element and every later element of the instruction.

The sequencer has three states. `S_IDLE` accepts an instruction. The transition *accept-single* leads to `S_SINGLE` and *accept-vector* leads to `S_EXPAND`. `S_SINGLE` pushes one entry and then takes *single-done* back to `S_IDLE`. `S_EXPAND` steps one element per cycle. It may *skip* a masked element, *push* an enabled one, *stall* in place while the queue is full, take *last-done* back to `S_IDLE` after the final element, or take *overflow-abort* back to `S_IDLE` when a register number is out of range.

Top module: `vec_expander`

## Requirements
- R1: After reset, `in_ready`=1, `out_empty`=1, `out_full`=0 and `err`=0. Every configuration entry resets to scalar, with length code 0 (length 1) and predicate 16'hFFFF.
- R2: A cycle with `cfg_we`=1 writes entry `cfg_reg`: the vectorised flag `cfg_vec`, the length code `cfg_len_m1` (length = code + 1, so 1 to 16) and the mask `cfg_pred`. The entry applies to every instruction accepted on a later cycle.
- R3: The vector length of an accepted instruction is taken from its destination register's entry. Elements are visited in ascending index order, from 0 to length-1.
- R4: In element `i`, each operand whose register is flagged vectorised becomes base+`i`. Each scalar operand keeps its base number, even when other operands are vectorised. The opcode is copied unchanged.
- R5: Bit `i` of the destination entry's mask (bit 0 = element 0) enables element `i`. A clear bit means the element produces no queue entry.
- R6: If none of the three operand registers is vectorised, or the length is 1, the instruction produces exactly one entry equal to the input, whatever the mask holds.
- R7: If an enabled element would give any vectorised operand a number above 31, `err` goes to 1. That element and all later elements are dropped, and earlier elements stay in the queue. `err` remains 1 until the next instruction is accepted, and it reads 0 from the cycle after that acceptance.
- R8: `in_ready` is 0 from the cycle after acceptance until the instruction's last entry has been pushed, or until the instruction is dropped.
- R9: The output queue holds 16 entries and shows `out_full` and `out_empty`. While the queue is full, expansion waits without losing or reordering any element.
- R10: When `out_empty`=0, the `out_*` fields show the oldest entry, and `out_pop` removes it. `out_pop` has no effect while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_opcode | input | 7 | Opcode of offered instruction |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg | input | 5 | Register whose entry is written |
| cfg_vec | input | 1 | Vectorised flag to store |
| cfg_len_m1 | input | 4 | Vector length minus one to store |
| cfg_pred | input | 16 | Predicate mask to store |
| out_pop | input | 1 | Remove oldest queue entry |
| out_opcode | output | 7 | Opcode of oldest entry |
| out_rd | output | 5 | Destination of oldest entry |
| out_rs1 | output | 5 | First source of oldest entry |
| out_rs2 | output | 5 | Second source of oldest entry |
| out_empty | output | 1 | Queue holds no entries |
| out_full | output | 1 | Queue holds 16 entries |
| err | output | 1 | Register number overflow in current or last instruction |

## Verification
The bench uses a destination at 30 with length 4. This checks that the two legal elements are kept while the overflow drop and `err` take effect. A design that checked overflow only at acceptance would lose those two elements, and one that checked too late would emit 32 truncated to 0. A sixteen-element instruction followed by a second instruction forces a stall with the queue full. A design that pushed while full would drop elements, and one that advanced its index during the stall would skip them. Sparse masks, scalar operands mixed with vectorised ones, a length-1 instruction with an all-zero mask and pops on an empty queue cover the remaining cases. These catch, in turn: an element index that counts only enabled elements, renaming applied to scalar operands, masking applied to a pass-through, and a read pointer that wraps while empty.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
    localparam int REG_W      = 5;
    localparam int NREG       = 1 << REG_W;
    localparam int OPC_W      = 7;
    localparam int MAX_LEN    = 16;
    localparam int IDX_W      = $clog2(MAX_LEN);
    localparam int FIFO_DEPTH = 16;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
    } elem_t;

    typedef struct packed {
        logic               vec;
        logic [IDX_W-1:0]   len_m1;
        logic [MAX_LEN-1:0] pred;
    } rcfg_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SINGLE = 2'd1,
        S_EXPAND = 2'd2
    } st_e;
endpackage

// File: rtl/vexp_cfg_table.sv
module vexp_cfg_table
    import vexp_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  rcfg_t                      wr_data,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    input  logic [$clog2(ENTRIES)-1:0] rs1_idx,
    input  logic [$clog2(ENTRIES)-1:0] rs2_idx,
    output rcfg_t                      rd_cfg,
    output logic                       rs1_vec,
    output logic                       rs2_vec
);
    localparam int IW = $clog2(ENTRIES);
    localparam rcfg_t RST_CFG = '{vec: 1'b0, len_m1: '0, pred: '1};

    rcfg_t tbl [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= RST_CFG;
            end else if (we && (wr_idx == IW'(g))) begin
                tbl[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_cfg  = tbl[rd_idx];
        rs1_vec = tbl[rs1_idx].vec;
        rs2_vec = tbl[rs2_idx].vec;
    end

    // R2: a written entry reads back on the cycle after the write
    a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == rd_idx) |=> (rd_cfg == $past(wr_data) || $past(rd_idx) != rd_idx
                                     || we));
endmodule

// File: rtl/vexp_fifo.sv
module vexp_fifo
    import vexp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  elem_t wr_data,
    input  logic  rd_en,
    output elem_t rd_data,
    output logic  full,
    output logic  empty
);
    localparam int AW = $clog2(DEPTH);

    elem_t         mem [DEPTH];
    logic [AW:0]   wr_ptr;
    logic [AW:0]   rd_ptr;
    logic [AW:0]   fill;
    logic          do_wr;
    logic          do_rd;

    always_comb begin
        empty   = (wr_ptr == rd_ptr);
        full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
        do_wr   = wr_en && !full;
        do_rd   = rd_en && !empty;
        fill    = wr_ptr - rd_ptr;
        rd_data = mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R9: the sequencer never offers an entry to a full queue
    a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);

    // R9: occupancy never exceeds the depth
    a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= (AW+1)'(DEPTH));

    // R10: a pop on an empty queue without a write leaves it empty
    a_r10_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> empty);
endmodule

// File: rtl/vexp_seq.sv
module vexp_seq
    import vexp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    output logic  in_ready,
    input  elem_t in_ins,
    input  rcfg_t rd_cfg,
    input  logic  rs1_vec,
    input  logic  rs2_vec,
    input  logic  fifo_full,
    output logic  push,
    output elem_t push_data,
    output logic  err
);
    st_e                st, st_nx;
    elem_t              ins;
    logic               v_rd, v_rs1, v_rs2;
    logic [IDX_W-1:0]   len_m1;
    logic [IDX_W-1:0]   idx;
    logic [MAX_LEN-1:0] pred;
    logic               err_q;

    logic [REG_W:0]     sum_rd, sum_rs1, sum_rs2;
    logic               ovf, en_el, last_el;
    logic               accept, single_in;
    logic               advance, ovf_hit;

    // element register numbers and element status
    always_comb begin
        sum_rd  = {1'b0, ins.rd}  + (v_rd  ? {{(REG_W+1-IDX_W){1'b0}}, idx} : '0);
        sum_rs1 = {1'b0, ins.rs1} + (v_rs1 ? {{(REG_W+1-IDX_W){1'b0}}, idx} : '0);
        sum_rs2 = {1'b0, ins.rs2} + (v_rs2 ? {{(REG_W+1-IDX_W){1'b0}}, idx} : '0);
        ovf     = sum_rd[REG_W] | sum_rs1[REG_W] | sum_rs2[REG_W];
        en_el   = pred[idx];
        last_el = (idx == len_m1);
        accept  = in_valid && (st == S_IDLE);
        single_in = !(rd_cfg.vec || rs1_vec || rs2_vec) || (rd_cfg.len_m1 == '0);
    end

    // next state and transition qualifiers
    always_comb begin
        st_nx   = st;
        advance = 1'b0;
        ovf_hit = 1'b0;
        unique case (st)
            S_IDLE: begin
                if (accept) begin
                    st_nx = single_in ? S_SINGLE : S_EXPAND;   // accept-single / accept-vector
                end
            end
            S_SINGLE: begin
                if (!fifo_full) begin
                    st_nx = S_IDLE;                            // single-done
                end
            end
            S_EXPAND: begin
                if (!en_el) begin
                    advance = 1'b1;                            // skip
                end else if (ovf) begin
                    ovf_hit = 1'b1;
                    st_nx   = S_IDLE;                          // overflow-abort
                end else if (!fifo_full) begin
                    advance = 1'b1;                            // push
                end
                if (advance && last_el) begin
                    st_nx = S_IDLE;                            // last-done
                end
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (st == S_IDLE);
        push      = 1'b0;
        push_data = ins;
        err       = err_q;
        unique case (st)
            S_IDLE: begin
            end
            S_SINGLE: begin
                push = !fifo_full;
            end
            S_EXPAND: begin
                push          = en_el && !ovf && !fifo_full;
                push_data.rd  = sum_rd[REG_W-1:0];
                push_data.rs1 = sum_rs1[REG_W-1:0];
                push_data.rs2 = sum_rs2[REG_W-1:0];
            end
            default: begin
            end
        endcase
    end

    // captured instruction, element index, error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins    <= '0;
            v_rd   <= 1'b0;
            v_rs1  <= 1'b0;
            v_rs2  <= 1'b0;
            len_m1 <= '0;
            pred   <= '0;
            idx    <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) begin
                ins    <= in_ins;
                v_rd   <= rd_cfg.vec;
                v_rs1  <= rs1_vec;
                v_rs2  <= rs2_vec;
                len_m1 <= rd_cfg.len_m1;
                pred   <= rd_cfg.pred;
                idx    <= '0;
            end else if (advance) begin
                idx <= idx + 1'b1;
            end
            if (accept) begin
                err_q <= 1'b0;
            end else if (ovf_hit) begin
                err_q <= 1'b1;
            end
        end
    end

    // R8: ready drops on the cycle after an accepted instruction
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3: the element index stays inside the captured length
    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXPAND) |-> (idx <= len_m1));

    // R9: a stalled enabled element is held, not skipped
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXPAND && fifo_full && en_el && !ovf) |=> (st == S_EXPAND && $stable(idx)));

    // R7: the error flag rises only after an out-of-range enabled element
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(st == S_EXPAND && en_el && ovf));

    // R5: a masked element never reaches the queue
    a_r5_masked_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_EXPAND && !en_el) |-> !push);
endmodule

// File: rtl/vec_expander.sv
module vec_expander
    import vexp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [OPC_W-1:0]   in_opcode,
    input  logic [REG_W-1:0]   in_rd,
    input  logic [REG_W-1:0]   in_rs1,
    input  logic [REG_W-1:0]   in_rs2,
    input  logic               cfg_we,
    input  logic [REG_W-1:0]   cfg_reg,
    input  logic               cfg_vec,
    input  logic [IDX_W-1:0]   cfg_len_m1,
    input  logic [MAX_LEN-1:0] cfg_pred,
    input  logic               out_pop,
    output logic [OPC_W-1:0]   out_opcode,
    output logic [REG_W-1:0]   out_rd,
    output logic [REG_W-1:0]   out_rs1,
    output logic [REG_W-1:0]   out_rs2,
    output logic               out_empty,
    output logic               out_full,
    output logic               err
);
    elem_t in_ins;
    rcfg_t cfg_wdata;
    rcfg_t rd_cfg;
    logic  rs1_vec, rs2_vec;
    logic  push;
    elem_t push_data;
    elem_t head;

    always_comb begin
        in_ins           = '{opc: in_opcode, rd: in_rd, rs1: in_rs1, rs2: in_rs2};
        cfg_wdata        = '{vec: cfg_vec, len_m1: cfg_len_m1, pred: cfg_pred};
        out_opcode       = head.opc;
        out_rd           = head.rd;
        out_rs1          = head.rs1;
        out_rs2          = head.rs2;
    end

    vexp_cfg_table #(.ENTRIES(NREG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wr_idx  (cfg_reg),
        .wr_data (cfg_wdata),
        .rd_idx  (in_rd),
        .rs1_idx (in_rs1),
        .rs2_idx (in_rs2),
        .rd_cfg  (rd_cfg),
        .rs1_vec (rs1_vec),
        .rs2_vec (rs2_vec)
    );

    vexp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_ins    (in_ins),
        .rd_cfg    (rd_cfg),
        .rs1_vec   (rs1_vec),
        .rs2_vec   (rs2_vec),
        .fifo_full (out_full),
        .push      (push),
        .push_data (push_data),
        .err       (err)
    );

    vexp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (push_data),
        .rd_en   (out_pop),
        .rd_data (head),
        .full    (out_full),
        .empty   (out_empty)
    );

    // R6: nothing is pushed on the cycle an instruction is accepted
    a_r6_no_push_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !push);
endmodule

// File: tb/vec_expander_bench.sv
`timescale 1ns/1ps
module vec_expander_bench;
    import vexp_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [OPC_W-1:0]   in_opcode = '0;
    logic [REG_W-1:0]   in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic               cfg_we = 1'b0;
    logic [REG_W-1:0]   cfg_reg = '0;
    logic               cfg_vec = 1'b0;
    logic [IDX_W-1:0]   cfg_len_m1 = '0;
    logic [MAX_LEN-1:0] cfg_pred = '0;
    logic               out_pop = 1'b0;
    logic [OPC_W-1:0]   out_opcode;
    logic [REG_W-1:0]   out_rd, out_rs1, out_rs2;
    logic               out_empty, out_full, err;

    vec_expander u_vec_expander (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_opcode(in_opcode), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_vec(cfg_vec),
        .cfg_len_m1(cfg_len_m1), .cfg_pred(cfg_pred),
        .out_pop(out_pop), .out_opcode(out_opcode), .out_rd(out_rd),
        .out_rs1(out_rs1), .out_rs2(out_rs2),
        .out_empty(out_empty), .out_full(out_full), .err(err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit          mvf   [32];
    int          mlen  [32];
    logic [15:0] mpred [32];
    logic [21:0] expq  [256];
    int          exp_n  = 0;
    int          exp_rd = 0;
    bit          m_err;

    task automatic check(string req, int act, int expv);
        n_vec++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic set_cfg(int r, bit v, int lm1, logic [15:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_reg = 5'(r); cfg_vec = v; cfg_len_m1 = 4'(lm1); cfg_pred = p;
        @(negedge clk);
        cfg_we = 1'b0;
        mvf[r] = v; mlen[r] = lm1 + 1; mpred[r] = p;
    endtask

    // expected element list computed from the requirements
    task automatic model(int op, int rd, int rs1, int rs2);
        bit anyv;
        int a, b, c;
        anyv  = mvf[rd] | mvf[rs1] | mvf[rs2];
        m_err = 1'b0;
        if (!anyv || mlen[rd] == 1) begin
            expq[exp_n] = {7'(op), 5'(rd), 5'(rs1), 5'(rs2)};
            exp_n++;
        end else begin
            for (int i = 0; i < mlen[rd]; i++) begin
                if (mpred[rd][i]) begin
                    a = rd  + (mvf[rd]  ? i : 0);
                    b = rs1 + (mvf[rs1] ? i : 0);
                    c = rs2 + (mvf[rs2] ? i : 0);
                    if (a > 31 || b > 31 || c > 31) begin
                        m_err = 1'b1;
                        break;
                    end
                    expq[exp_n] = {7'(op), 5'(a), 5'(b), 5'(c)};
                    exp_n++;
                end
            end
        end
    endtask

    task automatic issue(int op, int rd, int rs1, int rs2);
        model(op, rd, rs1, rs2);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_opcode = 7'(op); in_rd = 5'(rd); in_rs1 = 5'(rs1); in_rs2 = 5'(rs2);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 ready low after accept", int'(in_ready), 0);
    endtask

    task automatic wait_idle(string req);
        int t = 0;
        @(negedge clk);
        while (!in_ready && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(req, int'(in_ready), 1);
    endtask

    task automatic drain(string req);
        int t;
        while (exp_rd < exp_n) begin
            @(negedge clk);
            out_pop = 1'b0;
            t = 0;
            while (out_empty && t < 400) begin
                @(negedge clk);
                t++;
            end
            check(req, int'({out_opcode, out_rd, out_rs1, out_rs2}), int'(expq[exp_rd]));
            exp_rd++;
            out_pop = 1'b1;
        end
        @(negedge clk);
        out_pop = 1'b0;
        @(negedge clk);
        check({req, " queue empty after drain"}, int'(out_empty), 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_empty", int'(out_empty), 1);
        check("R1 out_full", int'(out_full), 0);
        check("R1 err", int'(err), 0);
    endtask

    task automatic t_all_vector();
        set_cfg(7, 1'b1, 2, 16'hFFFF);
        set_cfg(4, 1'b1, 2, 16'hFFFF);
        issue(51, 7, 4, 4);
        wait_idle("R8 ready returns");
        drain("R2 R3 R4 all vectorised");
    endtask

    task automatic t_mixed();
        set_cfg(4, 1'b0, 0, 16'hFFFF);
        set_cfg(1, 1'b1, 0, 16'hFFFF);
        issue(51, 7, 4, 1);
        wait_idle("R8 ready returns");
        drain("R4 scalar source fixed");
        set_cfg(3, 1'b0, 3, 16'hFFFF);
        issue(19, 3, 1, 0);
        wait_idle("R8 ready returns");
        drain("R3 length from scalar destination");
    endtask

    task automatic t_predicate();
        set_cfg(10, 1'b1, 5, 16'h002D);
        issue(51, 10, 10, 0);
        wait_idle("R8 ready returns");
        drain("R5 masked elements skipped");
    endtask

    task automatic t_passthrough();
        issue(99, 20, 21, 22);
        wait_idle("R8 ready returns");
        drain("R6 no vectorised operand");
        set_cfg(12, 1'b1, 0, 16'h0000);
        issue(51, 12, 12, 12);
        wait_idle("R8 ready returns");
        drain("R6 length one ignores mask");
    endtask

    task automatic t_overflow();
        set_cfg(30, 1'b1, 3, 16'hFFFF);
        issue(51, 30, 0, 0);
        wait_idle("R8 ready returns");
        check("R7 err raised", int'(err), int'(m_err));
        drain("R7 elements before overflow kept");
        check("R7 err held while idle", int'(err), 1);
        issue(99, 20, 21, 22);
        check("R7 err cleared by next accept", int'(err), 0);
        wait_idle("R8 ready returns");
        drain("R7 next instruction normal");
    endtask

    task automatic t_stall();
        set_cfg(16, 1'b1, 15, 16'hFFFF);
        issue(51, 16, 0, 0);
        wait_idle("R8 ready returns");
        check("R9 full at sixteen", int'(out_full), 1);
        issue(51, 7, 4, 1);
        repeat (3) @(negedge clk);
        check("R8 ready low while stalled", int'(in_ready), 0);
        check("R9 full during stall", int'(out_full), 1);
        drain("R9 stalled elements kept in order");
        wait_idle("R8 ready returns");
    endtask

    task automatic t_empty_pop();
        @(negedge clk);
        out_pop = 1'b1;
        repeat (2) @(negedge clk);
        out_pop = 1'b0;
        check("R10 empty pop keeps empty", int'(out_empty), 1);
        check("R10 empty pop not full", int'(out_full), 0);
        issue(5, 2, 3, 4);
        wait_idle("R8 ready returns");
        drain("R10 head after empty pops");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int r = 0; r < 32; r++) begin
            mvf[r] = 1'b0; mlen[r] = 1; mpred[r] = 16'hFFFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_vector();
        t_mixed();
        t_predicate();
        t_passthrough();
        t_overflow();
        t_stall();
        t_empty_pop();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL R8 watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule